// File: doc/BRIEF.md
# Serial Port Control and Interrupt Registers

This block is the word-addressed register front end of a high-speed serial port. It keeps the port's configuration word and its baud divisor. It turns one-cycle event pulses from the transmitter and receiver into sticky status flags, and it merges those flags with per-group enables into one interrupt line. The transmit and receive datapaths sit outside the block. They report to it through event pulses, condition levels and occupancy counts. The block passes them data-port writes and read strobes.

Software reaches five registers through a byte address. Bits 4:2 pick the word: 0 is the data port, 1 the occupancy word, 2 the interrupt status, 3 the configuration, 4 the divisor. Any other word index is unmapped. Error and transmit-request flags stay set until software writes a 1 to them. The two receive-side flags follow their condition inputs directly.

Top module: `hsu_csr_top`

## Requirements
- R1: After reset the configuration word reads 0x0000_2800 (sampling offset 20 in bits 13:9, every other field 0), the divisor reads 0xFF, every status flag reads 0 and irq is 0.
- R2: A pulse on ev_tx_req, ev_frame_err, ev_break or ev_overrun sets status bit 0, 3, 4 or 5 respectively from the next cycle, and the bit stays set with no further pulse.
- R3: A write to word 2 clears each of status bits 0, 3, 4 and 5 whose written bit is 1. A written 0 leaves the bit alone. An event in the same cycle as its clear leaves the bit set.
- R4: Status bit 1 shows rx_trig_hit and bit 2 shows rx_idle_tmo in the same cycle. Writes to word 2 have no effect on them.
- R5: irq is high when any of these holds: bit 0 with configuration bit 5 set; bit 1 or bit 2 with configuration bit 6 set; bit 3, 4 or 5 with configuration bit 7 set.
- R6: A write to word 3 stores wdata[21:0]. The stored word reads back in bits 21:0 with zeros above, and drives cfg_word. The fields are: tx trigger 1:0, rx trigger 4:2, enables 7:5, break 8, offset 13:9, CTS enable 14, CTS invert 15, timeout 17:16, RTS enable 18, RTS depth 20:19, RTS invert 21.
- R7: A write to word 4 stores wdata[7:0] as the divisor. It reads back with zeros above and drives rate_div.
- R8: Word 1 reads tx_count in bits 15:8 and rx_count in bits 7:0. Writes to it change nothing.
- R9: A write to word 0 raises tx_push with tx_byte = wdata[7:0] in that cycle. A read strobe to word 0 raises rx_pop. Word 0 reads rx_brk_char in bit 10, rx_bad in bit 9, rx_none in bit 8 and rx_byte in bits 7:0.
- R10: Writing 1 to status bit 6 sets status bit 0, and this set overrides a clear in the same write. Bit 6 always reads 0.
- R11: Unmapped words read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address, word index in bits 4:2 |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the addressed word (combinational) |
| ev_tx_req | input | 1 | Transmitter wants data (pulse) |
| ev_frame_err | input | 1 | Framing error seen (pulse) |
| ev_break | input | 1 | Break received (pulse) |
| ev_overrun | input | 1 | Receive overrun (pulse) |
| rx_trig_hit | input | 1 | Receive occupancy at trigger (level) |
| rx_idle_tmo | input | 1 | Receive idle timeout (level) |
| tx_count | input | LVL_W | Transmit queue occupancy |
| rx_count | input | LVL_W | Receive queue occupancy |
| rx_byte | input | 8 | Head character of receive queue |
| rx_none | input | 1 | Receive queue empty |
| rx_bad | input | 1 | Head character has framing error |
| rx_brk_char | input | 1 | Head character is a break |
| tx_push | output | 1 | Push tx_byte into transmit queue |
| tx_byte | output | 8 | Character to transmit |
| rx_pop | output | 1 | Pop receive queue head |
| irq | output | 1 | Interrupt request |
| cfg_word | output | 22 | Configuration fields |
| rate_div | output | 8 | Baud divisor |

## Verification
The hardest situation to reach is an event pulse arriving in the same cycle as the write that clears its flag. A second hard case is a status write that both clears and soft-sets the transmit request. Both come down to one cycle, so directed sequences line up each event with a matching status write. A long random phase then fires events and status writes with independent probabilities at high density, so every flag meets its own clear many times while the enables and level inputs change under it.

// File: rtl/hsu_csr_pkg.sv
package hsu_csr_pkg;

    localparam int DATA_W     = 32;
    localparam int CTRL_W     = 22;
    localparam int NUM_STICKY = 4;

    // sticky flag slots
    localparam int ST_TX  = 0;
    localparam int ST_FE  = 1;
    localparam int ST_BRK = 2;
    localparam int ST_OVR = 3;

    // status word bit used by the software set of the transmit flag
    localparam int SOFT_TX_BIT = 6;

    typedef enum logic [2:0] {
        W_DATA  = 3'd0,
        W_LEVEL = 3'd1,
        W_STAT  = 3'd2,
        W_CTRL  = 3'd3,
        W_RATE  = 3'd4
    } word_e;

    typedef struct packed {
        logic       rts_inv;    // 21
        logic [1:0] rts_depth;  // 20:19
        logic       rts_en;     // 18
        logic [1:0] tmo_sel;    // 17:16
        logic       cts_inv;    // 15
        logic       cts_en;     // 14
        logic [4:0] samp_ofs;   // 13:9
        logic       brk_force;  // 8
        logic       en_err;     // 7
        logic       en_rx;      // 6
        logic       en_tx;      // 5
        logic [2:0] rx_trig;    // 4:2
        logic [1:0] tx_trig;    // 1:0
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{samp_ofs: 5'd20, default: '0};
    localparam logic [7:0] RATE_RST = 8'hFF;

    // position of each sticky slot inside the status word
    function automatic int stat_pos(input int slot);
        case (slot)
            ST_TX:   return 0;
            ST_FE:   return 3;
            ST_BRK:  return 4;
            default: return 5;
        endcase
    endfunction

endpackage

// File: rtl/hsu_sticky_bank.sv
module hsu_sticky_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                q_o[i] <= 1'b0;
            else if (set_i[i])
                q_o[i] <= 1'b1;
            else if (clr_i[i])
                q_o[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/hsu_cfg_regs.sv
module hsu_cfg_regs
    import hsu_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic              wr_rate,
    input  logic [CTRL_W-1:0] wval,
    output ctrl_t             ctrl_o,
    output logic [7:0]        rate_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_o <= CTRL_RST;
            rate_o <= RATE_RST;
        end else begin
            if (wr_ctrl) ctrl_o <= ctrl_t'(wval);
            if (wr_rate) rate_o <= wval[7:0];
        end
    end
endmodule

// File: rtl/hsu_irq_merge.sv
module hsu_irq_merge
    import hsu_csr_pkg::*;
(
    input  logic [NUM_STICKY-1:0] sticky,
    input  logic                  rx_trig,
    input  logic                  rx_tmo,
    input  ctrl_t                 ctrl,
    output logic                  irq_o
);
    logic tx_src, rx_src, err_src;

    always_comb begin
        tx_src  = sticky[ST_TX] & ctrl.en_tx;
        rx_src  = (rx_trig | rx_tmo) & ctrl.en_rx;
        err_src = (sticky[ST_FE] | sticky[ST_BRK] | sticky[ST_OVR]) & ctrl.en_err;
        irq_o   = tx_src | rx_src | err_src;
    end
endmodule

// File: rtl/hsu_csr_top.sv
module hsu_csr_top
    import hsu_csr_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int LVL_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              ev_tx_req,
    input  logic              ev_frame_err,
    input  logic              ev_break,
    input  logic              ev_overrun,
    input  logic              rx_trig_hit,
    input  logic              rx_idle_tmo,
    input  logic [LVL_W-1:0]  tx_count,
    input  logic [LVL_W-1:0]  rx_count,
    input  logic [7:0]        rx_byte,
    input  logic              rx_none,
    input  logic              rx_bad,
    input  logic              rx_brk_char,
    output logic              tx_push,
    output logic [7:0]        tx_byte,
    output logic              rx_pop,
    output logic              irq,
    output logic [CTRL_W-1:0] cfg_word,
    output logic [7:0]        rate_div
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]      widx;
    logic                  hit_data, hit_level, hit_stat, hit_ctrl, hit_rate;
    logic [NUM_STICKY-1:0] st_set, st_clr, st_q;
    logic [NUM_STICKY-1:0] ev_vec;
    ctrl_t                 ctrl_q;
    logic [7:0]            rate_q;
    logic [DATA_W-1:0]     stat_word, level_word;
    logic                  unused_wbits;

    assign unused_wbits = ^{wdata[DATA_W-1:CTRL_W], addr[1:0]};

    assign widx      = addr[ADDR_W-1:2];
    assign hit_data  = (widx == IDX_W'(W_DATA));
    assign hit_level = (widx == IDX_W'(W_LEVEL));
    assign hit_stat  = (widx == IDX_W'(W_STAT));
    assign hit_ctrl  = (widx == IDX_W'(W_CTRL));
    assign hit_rate  = (widx == IDX_W'(W_RATE));

    assign ev_vec[ST_TX]  = ev_tx_req;
    assign ev_vec[ST_FE]  = ev_frame_err;
    assign ev_vec[ST_BRK] = ev_break;
    assign ev_vec[ST_OVR] = ev_overrun;

    for (genvar s = 0; s < NUM_STICKY; s++) begin : g_clr
        assign st_clr[s] = wr_en & hit_stat & wdata[stat_pos(s)];
        if (s == ST_TX) begin : g_soft
            assign st_set[s] = ev_vec[s] | (wr_en & hit_stat & wdata[SOFT_TX_BIT]);
        end else begin : g_plain
            assign st_set[s] = ev_vec[s];
        end
    end

    hsu_sticky_bank #(.N(NUM_STICKY)) u_sticky (
        .clk   (clk),
        .rst   (rst),
        .set_i (st_set),
        .clr_i (st_clr),
        .q_o   (st_q)
    );

    hsu_cfg_regs u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_ctrl (wr_en & hit_ctrl),
        .wr_rate (wr_en & hit_rate),
        .wval    (wdata[CTRL_W-1:0]),
        .ctrl_o  (ctrl_q),
        .rate_o  (rate_q)
    );

    hsu_irq_merge u_irq (
        .sticky  (st_q),
        .rx_trig (rx_trig_hit),
        .rx_tmo  (rx_idle_tmo),
        .ctrl    (ctrl_q),
        .irq_o   (irq)
    );

    always_comb begin
        stat_word    = '0;
        stat_word[1] = rx_trig_hit;
        stat_word[2] = rx_idle_tmo;
        for (int s = 0; s < NUM_STICKY; s++)
            stat_word[stat_pos(s)] = st_q[s];

        level_word = '0;
        level_word[LVL_W-1:0]  = rx_count;
        level_word[8 +: LVL_W] = tx_count;
    end

    always_comb begin
        rdata = '0;
        if (hit_data)       rdata[10:0] = {rx_brk_char, rx_bad, rx_none, rx_byte};
        else if (hit_level) rdata = level_word;
        else if (hit_stat)  rdata = stat_word;
        else if (hit_ctrl)  rdata[CTRL_W-1:0] = ctrl_q;
        else if (hit_rate)  rdata[7:0] = rate_q;
    end

    assign tx_push  = wr_en & hit_data;
    assign tx_byte  = wdata[7:0];
    assign rx_pop   = rd_en & hit_data;
    assign cfg_word = ctrl_q;
    assign rate_div = rate_q;

endmodule

// File: rtl/hsu_csr_chk.sv
module hsu_csr_chk
    import hsu_csr_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  wr_en,
    input logic [ADDR_W-1:0]     addr,
    input logic [DATA_W-1:0]     wdata,
    input logic                  ev_frame_err,
    input logic                  ev_overrun,
    input logic [NUM_STICKY-1:0] st_q,
    input ctrl_t                 ctrl_q,
    input logic [7:0]            rate_q,
    input logic                  irq
);
    logic [ADDR_W-3:0] w;
    assign w = addr[ADDR_W-1:2];

    // R2: a framing error pulse leaves its flag set
    a_r2_fe_latches: assert property (@(posedge clk) disable iff (rst)
        ev_frame_err |=> st_q[ST_FE]);

    // R3: write-one clears overrun when no new overrun arrives
    a_r3_ovr_clears: assert property (@(posedge clk) disable iff (rst)
        (wr_en && w == 2 && wdata[5] && !ev_overrun) |=> !st_q[ST_OVR]);

    // R5: with all enables off the line stays low
    a_r5_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.en_tx && !ctrl_q.en_rx && !ctrl_q.en_err) |-> !irq);

    // R6: configuration changes only through its own word
    a_r6_ctrl_holds: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && w == 3) |=> $stable(ctrl_q));

    // R11: writes to unmapped words leave config and divisor alone
    a_r11_unmapped_wr: assert property (@(posedge clk) disable iff (rst)
        (wr_en && w > 4) |=> ($stable(ctrl_q) && $stable(rate_q)));
endmodule

bind hsu_csr_top hsu_csr_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .addr         (addr),
    .wdata        (wdata),
    .ev_frame_err (ev_frame_err),
    .ev_overrun   (ev_overrun),
    .st_q         (st_q),
    .ctrl_q       (ctrl_q),
    .rate_q       (rate_q),
    .irq          (irq)
);

// File: tb/tb_hsu_csr_top.sv
`timescale 1ns/1ps
module tb_hsu_csr_top;
    logic        clk = 0;
    logic        rst = 1;
    logic        wr_en = 0, rd_en = 0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ev_tx_req = 0, ev_frame_err = 0, ev_break = 0, ev_overrun = 0;
    logic        rx_trig_hit = 0, rx_idle_tmo = 0;
    logic [7:0]  tx_count = '0, rx_count = '0, rx_byte = '0;
    logic        rx_none = 1, rx_bad = 0, rx_brk_char = 0;
    logic        tx_push, rx_pop, irq;
    logic [7:0]  tx_byte, rate_div;
    logic [21:0] cfg_word;

    always #2 clk = ~clk;

    hsu_csr_top dut (.*);

    int vectors = 0, miscompares = 0;
    bit done = 0, running = 0;

    // behavioural reference state
    logic [21:0] m_ctrl;
    logic [7:0]  m_rate;
    bit m_tx, m_fe, m_brk, m_ovr;

    always @(posedge clk) begin
        int w;
        w = addr[4:2];
        if (rst) begin
            m_ctrl = 22'h002800; m_rate = 8'hFF;
            m_tx = 0; m_fe = 0; m_brk = 0; m_ovr = 0;
        end else begin
            if (wr_en && w == 2) begin
                if (wdata[0]) m_tx = 0;
                if (wdata[3]) m_fe = 0;
                if (wdata[4]) m_brk = 0;
                if (wdata[5]) m_ovr = 0;
                if (wdata[6]) m_tx = 1;
            end
            if (ev_tx_req)    m_tx = 1;
            if (ev_frame_err) m_fe = 1;
            if (ev_break)     m_brk = 1;
            if (ev_overrun)   m_ovr = 1;
            if (wr_en && w == 3) m_ctrl = wdata[21:0];
            if (wr_en && w == 4) m_rate = wdata[7:0];
        end
    end

    function automatic logic [31:0] exp_rdata();
        case (int'(addr[4:2]))
            0: return {21'b0, rx_brk_char, rx_bad, rx_none, rx_byte};
            1: return {16'b0, tx_count, rx_count};
            2: return {26'b0, m_ovr, m_brk, m_fe, rx_idle_tmo, rx_trig_hit, m_tx};
            3: return {10'b0, m_ctrl};
            4: return {24'b0, m_rate};
            default: return 32'b0;
        endcase
    endfunction

    function automatic string rd_tag();
        case (int'(addr[4:2]))
            0: return "R9";
            1: return "R8";
            2: return "R2/R3/R4/R10";
            3: return "R6";
            4: return "R7";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // every-cycle comparison, one ns after the inputs change
    always @(negedge clk) begin
        if (running) begin
            #1;
            chk(rd_tag(), rdata, exp_rdata());
            chk("R5", {31'b0, irq}, {31'b0, (m_tx & m_ctrl[5]) |
                ((rx_trig_hit | rx_idle_tmo) & m_ctrl[6]) |
                ((m_fe | m_brk | m_ovr) & m_ctrl[7])});
            chk("R6", {10'b0, cfg_word}, {10'b0, m_ctrl});
            chk("R7", {24'b0, rate_div}, {24'b0, m_rate});
            chk("R9", {31'b0, tx_push}, {31'b0, wr_en && addr[4:2] == 0});
            chk("R9", {31'b0, rx_pop}, {31'b0, rd_en && addr[4:2] == 0});
            if (wr_en) chk("R9", {24'b0, tx_byte}, {24'b0, wdata[7:0]});
        end
    end

    task automatic idle();
        wr_en = 0; rd_en = 0;
        ev_tx_req = 0; ev_frame_err = 0; ev_break = 0; ev_overrun = 0;
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk); idle(); wr_en = 1; addr = 5'(a); wdata = d;
    endtask

    task automatic look(int a);
        @(negedge clk); idle(); addr = 5'(a);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0; running = 1;

        // R1: reset values
        look(12); #2 chk("R1", rdata, 32'h0000_2800);
        look(16); #2 chk("R1", rdata, 32'h0000_00FF);
        look(8);  #2 chk("R1", rdata, 32'h0);
        chk("R1", {31'b0, irq}, 32'h0);

        // R2: framing error latches and holds
        @(negedge clk); idle(); addr = 5'd8; ev_frame_err = 1;
        look(8); #2 chk("R2", rdata, 32'h8);
        look(8); #2 chk("R2", rdata, 32'h8);

        // R3: zero write keeps, one write clears, event beats clear
        wr(8, 32'h0);  look(8); #2 chk("R3", rdata, 32'h8);
        wr(8, 32'h8);  look(8); #2 chk("R3", rdata, 32'h0);
        @(negedge clk); ev_overrun = 1; look(8); #2 chk("R2", rdata, 32'h20);
        wr(8, 32'h20); ev_overrun = 1; look(8); #2 chk("R3", rdata, 32'h20);
        wr(8, 32'h20); look(8); #2 chk("R3", rdata, 32'h0);

        // R4: level flags follow inputs, writes do not touch them
        look(8); rx_trig_hit = 1; #2 chk("R4", rdata, 32'h2);
        wr(8, 32'h6); rx_idle_tmo = 1; #2 chk("R4", rdata, 32'h6);
        look(8); rx_trig_hit = 0; rx_idle_tmo = 0; #2 chk("R4", rdata, 32'h0);

        // R5: receive enable routes the level flag
        wr(12, 32'h2800 | 32'h40); look(8); rx_trig_hit = 1;
        #2 chk("R5", {31'b0, irq}, 32'h1);
        look(8); rx_trig_hit = 0; #2 chk("R5", {31'b0, irq}, 32'h0);

        // R10: soft set of transmit flag, set wins over clear
        wr(8, 32'h41); look(8); #2 chk("R10", rdata, 32'h1);
        wr(8, 32'h1);  look(8); #2 chk("R3", rdata, 32'h0);

        // R8 / R11: writes to level and unmapped words change nothing
        wr(4, 32'hFFFF_FFFF); wr(28, 32'hFFFF_FFFF);
        look(28); #2 chk("R11", rdata, 32'h0);
        look(12); #2 chk("R11", rdata, 32'h2840);

        // R9: data port strobes
        @(negedge clk); idle(); rd_en = 1; addr = 0; rx_byte = 8'hA5; rx_bad = 1;
        #2 chk("R9", {31'b0, rx_pop}, 32'h1);

        // dense random phase
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            idle();
            case ($urandom_range(0, 6))
                0: addr = 5'd0;  1: addr = 5'd4;  2: addr = 5'd8;
                3: addr = 5'd8;  4: addr = 5'd12; 5: addr = 5'd16;
                default: addr = 5'd28;
            endcase
            wr_en = ($urandom_range(0, 3) == 0);
            rd_en = ($urandom_range(0, 3) == 0);
            wdata = $urandom;
            ev_tx_req    = ($urandom_range(0, 5) == 0);
            ev_frame_err = ($urandom_range(0, 5) == 0);
            ev_break     = ($urandom_range(0, 5) == 0);
            ev_overrun   = ($urandom_range(0, 5) == 0);
            rx_trig_hit  = ($urandom_range(0, 3) == 0);
            rx_idle_tmo  = ($urandom_range(0, 3) == 0);
            tx_count = 8'($urandom); rx_count = 8'($urandom); rx_byte = 8'($urandom);
            rx_none = $urandom_range(0, 1); rx_bad = $urandom_range(0, 1);
            rx_brk_char = $urandom_range(0, 1);
        end

        @(negedge clk); idle(); running = 0;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule